// File: doc/BRIEF.md
# Switchable Output Port Predictor

This unit sits on one input channel of a mesh router and guesses which output port the next packet on that channel will take. The router can then reserve the crossbar before the head flit arrives, while the channel is still idle. If the guess is right, the routing and arbitration steps are skipped. If the guess is wrong, the flit is killed and resent, and the cost is no worse than a normal pipeline pass.

The unit runs four guessing schemes side by side:

- **Straight-ahead:** assumes the packet keeps its direction of travel.
- **Last-port:** repeats the port the previous packet used.
- **Custom:** takes the port from a configuration input.
- **Frequency-context:** picks the port that has most often followed the last used port.

In static mode a configuration field fixes the active scheme. In dynamic mode every scheme counts its own hits against the routed port. At the end of each configurable window the scheme with the most hits becomes active for the next window.

Ports are coded in 3 bits: 0 = X+, 1 = X-, 2 = Y+, 3 = Y-, 4 = local, 7 = none. Scheme codes are 0 = straight-ahead, 1 = last-port, 2 = custom, 3 = frequency-context. A route event is a cycle with `route_vld_i` high. Only ports 0 to 4 in a route event count as valid ports.

Top module: `port_predictor`

## Requirements
- R1: After reset, the active scheme is straight-ahead (code 0), the last-port history holds none (7), and all frequency counters and hit counters are zero.
- R2: When `idle_i` is low, `pred_port_o` is 7 and `pred_vld_o` is 0. When `idle_i` is high, `pred_port_o` shows the active scheme's guess, and `pred_vld_o` is 1 exactly when that guess is not 7.
- R3: Straight-ahead guesses `arrive_dir_i` when it is 0 to 3, and guesses 7 for any other value.
- R4: Last-port guesses the port of the most recent route event that carried a valid port. Route events with ports 5 to 7 leave the history unchanged. Before any valid route event, the guess is 7.
- R5: Custom guesses `cfg_custom_port_i` when it is 0 to 4, and guesses 7 otherwise.
- R6: Frequency-context behaviour:
  - Each valid route event increments, saturating at 15, the counter indexed by (previous valid port, this port). No counter moves if there was no previous valid port.
  - The guess is the port with the largest count in the row of the current last port, with ties going to the lowest port index.
  - The guess is 7 if there is no last port or if that row is all zero.
- R7: With `cfg_dynamic_i` low, `cfg_scheme_i` selects the active scheme in the same cycle it changes.
- R8: With `cfg_dynamic_i` high, a route event adds one hit to each scheme whose current guess equals `route_port_i` and is not 7. Hit counters saturate at 2^HIT_W-1 and never wrap.
- R9: With `cfg_dynamic_i` high, a window ends on the `cfg_epoch_i`-th dynamic cycle; a value of 0 acts as 1. At the end of a window:
  - The scheme with the highest count becomes active from the next cycle. The count includes any hit in that final cycle, and ties go to the lowest scheme code.
  - All hit counters clear and the window restarts.
- R10: While `cfg_dynamic_i` is low, the hit counters and the window count are held at zero and the stored active scheme follows `cfg_scheme_i`. On entering dynamic mode, that scheme stays active until the first window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Channel idle, so a guess may be offered |
| arrive_dir_i | input | 3 | Travel direction of traffic on this channel (port code) |
| route_vld_i | input | 1 | A head flit has been routed this cycle |
| route_port_i | input | 3 | Output port the head flit was routed to |
| cfg_dynamic_i | input | 1 | 1 = adaptive scheme choice, 0 = fixed |
| cfg_scheme_i | input | 2 | Fixed scheme code |
| cfg_custom_port_i | input | 3 | Port returned by the custom scheme |
| cfg_epoch_i | input | EP_W | Window length in cycles for adaptive choice |
| pred_port_o | output | 3 | Predicted port, 7 when none |
| pred_vld_o | output | 1 | Predicted port is usable |

## Verification
Most internal state can only be seen through the active scheme's guess. A corrupted history register or frequency counter therefore shows up in the same cycle as a wrong `pred_port_o`, but only while that scheme is active and the channel is idle. Bad hit counts or a bad window count stay hidden until the window closes. They then show one cycle later as a different scheme being chosen, which can change every later guess. For that reason the bench keeps a behavioural model of all counters, compares every cycle, and uses short windows so a selection error surfaces within a few cycles.

// File: rtl/port_pred_pkg.sv
package port_pred_pkg;
  localparam int NPORTS = 5;
  localparam int NSCH   = 4;
  typedef logic [2:0] port_t;
  localparam port_t PORT_NONE = 3'd7;
  typedef enum logic [1:0] {
    SCH_STRAIGHT = 2'd0,
    SCH_LAST     = 2'd1,
    SCH_CUSTOM   = 2'd2,
    SCH_FREQ     = 2'd3
  } scheme_e;

  function automatic logic port_ok(port_t p);
    return p < port_t'(NPORTS);
  endfunction
endpackage

// File: rtl/pp_last_port.sv
module pp_last_port
  import port_pred_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  port_t port_i,
  output port_t last_o
);
  port_t last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    last_q <= PORT_NONE;
    else if (upd_i && port_ok(port_i)) last_q <= port_i;
  end

  assign last_o = last_q;

  // R4
  last_follows_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && port_ok(port_i)) |=> (last_q == $past(port_i)));
  // R4
  last_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !port_ok(port_i)) |=> $stable(last_q));
endmodule

// File: rtl/pp_freq_table.sv
module pp_freq_table
  import port_pred_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  port_t ctx_i,
  input  port_t port_i,
  output port_t pred_o
);
  logic [CNT_W-1:0] cnt_q [NPORTS][NPORTS];
  logic [CNT_W-1:0] row   [NPORTS];

  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_row
    for (genvar gj = 0; gj < NPORTS; gj++) begin : g_col
      logic bump;
      assign bump = upd_i && port_ok(port_i) && (ctx_i == port_t'(gi)) && (port_i == port_t'(gj));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q[gi][gj] <= '0;
        else if (bump && cnt_q[gi][gj] != '1) cnt_q[gi][gj] <= cnt_q[gi][gj] + 1'b1;
      end
      // R6
      freq_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q[gi][gj] == '1) |=> (cnt_q[gi][gj] == '1));
    end
  end

  always_comb begin
    for (int j = 0; j < NPORTS; j++) row[j] = '0;
    for (int i = 0; i < NPORTS; i++)
      if (ctx_i == port_t'(i))
        for (int j = 0; j < NPORTS; j++) row[j] = cnt_q[i][j];
  end

  always_comb begin
    logic [CNT_W-1:0] best;
    best   = '0;
    pred_o = PORT_NONE;
    for (int j = 0; j < NPORTS; j++) begin
      if (row[j] > best) begin
        best   = row[j];
        pred_o = port_t'(j);
      end
    end
  end

  // R6
  freq_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_ok(ctx_i) |-> (pred_o == PORT_NONE));
endmodule

// File: rtl/pp_scheme_select.sv
module pp_scheme_select
  import port_pred_pkg::*;
#(
  parameter int HIT_W = 16,
  parameter int EP_W  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dyn_i,
  input  scheme_e         cfg_scheme_i,
  input  logic            route_vld_i,
  input  port_t           route_port_i,
  input  port_t           pred_i [NSCH],
  input  logic [EP_W-1:0] cfg_epoch_i,
  output scheme_e         active_o
);
  logic [HIT_W-1:0] hit_q   [NSCH];
  logic [HIT_W-1:0] hit_nxt [NSCH];
  logic [EP_W-1:0]  ep_q;
  logic [EP_W:0]    ep_inc;
  logic             tick;
  scheme_e          active_q;
  scheme_e          winner;

  assign ep_inc = {1'b0, ep_q} + 1'b1;
  assign tick   = dyn_i && (ep_inc >= {1'b0, cfg_epoch_i});

  for (genvar gs = 0; gs < NSCH; gs++) begin : g_hit
    logic hit;
    assign hit = route_vld_i && (pred_i[gs] != PORT_NONE) && (pred_i[gs] == route_port_i);
    assign hit_nxt[gs] = (hit && hit_q[gs] != '1) ? hit_q[gs] + 1'b1 : hit_q[gs];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            hit_q[gs] <= '0;
      else if (!dyn_i || tick) hit_q[gs] <= '0;
      else                    hit_q[gs] <= hit_nxt[gs];
    end

    // R8
    hit_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_q[gs] == '1 && dyn_i && !tick) |=> (hit_q[gs] == '1));
    // R10
    hit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dyn_i |=> (hit_q[gs] == '0));
  end

  always_comb begin
    logic [HIT_W-1:0] best;
    best   = hit_nxt[0];
    winner = SCH_STRAIGHT;
    for (int s = 1; s < NSCH; s++) begin
      if (hit_nxt[s] > best) begin
        best   = hit_nxt[s];
        winner = scheme_e'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep_q     <= '0;
      active_q <= SCH_STRAIGHT;
    end else if (!dyn_i) begin
      ep_q     <= '0;
      active_q <= cfg_scheme_i;
    end else if (tick) begin
      ep_q     <= '0;
      active_q <= winner;
    end else begin
      ep_q     <= ep_inc[EP_W-1:0];
    end
  end

  assign active_o = dyn_i ? active_q : cfg_scheme_i;

  // R9
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dyn_i && !tick) |=> $stable(active_q));
  // R9
  window_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (ep_q == '0));
  // R10
  ep_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dyn_i |=> (ep_q == '0 && active_q == $past(cfg_scheme_i)));
endmodule

// File: rtl/port_predictor.sv
module port_predictor
  import port_pred_pkg::*;
#(
  parameter int HIT_W = 16,
  parameter int EP_W  = 16,
  parameter int CNT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            idle_i,
  input  logic [2:0]      arrive_dir_i,
  input  logic            route_vld_i,
  input  logic [2:0]      route_port_i,
  input  logic            cfg_dynamic_i,
  input  logic [1:0]      cfg_scheme_i,
  input  logic [2:0]      cfg_custom_port_i,
  input  logic [EP_W-1:0] cfg_epoch_i,
  output logic [2:0]      pred_port_o,
  output logic            pred_vld_o
);
  port_t   last_port;
  port_t   freq_pred;
  port_t   pred [NSCH];
  scheme_e active;
  port_t   sel_pred;

  pp_last_port u_last (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (route_vld_i),
    .port_i (route_port_i),
    .last_o (last_port)
  );

  pp_freq_table #(.CNT_W(CNT_W)) u_freq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (route_vld_i),
    .ctx_i  (last_port),
    .port_i (route_port_i),
    .pred_o (freq_pred)
  );

  assign pred[SCH_STRAIGHT] = (arrive_dir_i < 3'd4) ? arrive_dir_i : PORT_NONE;
  assign pred[SCH_LAST]     = last_port;
  assign pred[SCH_CUSTOM]   = port_ok(cfg_custom_port_i) ? cfg_custom_port_i : PORT_NONE;
  assign pred[SCH_FREQ]     = freq_pred;

  pp_scheme_select #(.HIT_W(HIT_W), .EP_W(EP_W)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dyn_i        (cfg_dynamic_i),
    .cfg_scheme_i (scheme_e'(cfg_scheme_i)),
    .route_vld_i  (route_vld_i),
    .route_port_i (route_port_i),
    .pred_i       (pred),
    .cfg_epoch_i  (cfg_epoch_i),
    .active_o     (active)
  );

  assign sel_pred    = pred[active];
  assign pred_port_o = idle_i ? sel_pred : PORT_NONE;
  assign pred_vld_o  = idle_i && (sel_pred != PORT_NONE);

  // R2
  pred_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_vld_o |-> (pred_port_o < 3'd5));
  // R7
  static_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_dynamic_i && idle_i && cfg_scheme_i == 2'd2) |-> (pred_port_o == pred[SCH_CUSTOM]));
endmodule

// File: tb/port_predictor_tb_top.sv
module port_predictor_tb_top;
  localparam int HIT_W = 4;
  localparam int EP_W  = 16;
  localparam int HMAX  = (1 << HIT_W) - 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            idle_i = 1'b1;
  logic [2:0]      arrive_dir_i = 3'd0;
  logic            route_vld_i = 1'b0;
  logic [2:0]      route_port_i = 3'd0;
  logic            cfg_dynamic_i = 1'b0;
  logic [1:0]      cfg_scheme_i = 2'd0;
  logic [2:0]      cfg_custom_port_i = 3'd0;
  logic [EP_W-1:0] cfg_epoch_i = 16'd8;
  logic [2:0]      pred_port_o;
  logic            pred_vld_o;

  port_predictor #(.HIT_W(HIT_W), .EP_W(EP_W), .CNT_W(4)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  int    n_vec = 0, n_bad = 0, n_cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  int m_last, m_active, m_ep;
  int m_cnt [5][5];
  int m_hit [4];

  function automatic int pred_of(int s);
    int best, bv;
    case (s)
      0: return (arrive_dir_i < 4) ? int'(arrive_dir_i) : 7;
      1: return m_last;
      2: return (cfg_custom_port_i < 5) ? int'(cfg_custom_port_i) : 7;
      default: begin
        if (m_last == 7) return 7;
        best = 7; bv = 0;
        for (int j = 0; j < 5; j++)
          if (m_cnt[m_last][j] > bv) begin bv = m_cnt[m_last][j]; best = j; end
        return best;
      end
    endcase
  endfunction

  task automatic model_reset();
    m_last = 7; m_active = 0; m_ep = 0;
    for (int i = 0; i < 5; i++) for (int j = 0; j < 5; j++) m_cnt[i][j] = 0;
    for (int s = 0; s < 4; s++) m_hit[s] = 0;
  endtask

  task automatic model_step();
    int p [4];
    int hn [4];
    int win, bv, rp;
    rp = int'(route_port_i);
    for (int s = 0; s < 4; s++) p[s] = pred_of(s);
    if (cfg_dynamic_i) begin
      for (int s = 0; s < 4; s++) begin
        hn[s] = m_hit[s];
        if (route_vld_i && p[s] != 7 && p[s] == rp && hn[s] < HMAX) hn[s]++;
      end
      if (m_ep + 1 >= int'(cfg_epoch_i)) begin
        win = 0; bv = hn[0];
        for (int s = 1; s < 4; s++) if (hn[s] > bv) begin bv = hn[s]; win = s; end
        m_active = win; m_ep = 0;
        for (int s = 0; s < 4; s++) m_hit[s] = 0;
      end else begin
        for (int s = 0; s < 4; s++) m_hit[s] = hn[s];
        m_ep++;
      end
    end else begin
      m_active = int'(cfg_scheme_i); m_ep = 0;
      for (int s = 0; s < 4; s++) m_hit[s] = 0;
    end
    if (route_vld_i && rp < 5) begin
      if (m_last != 7 && m_cnt[m_last][rp] < 15) m_cnt[m_last][rp]++;
      m_last = rp;
    end
  endtask

  task automatic check();
    int sel, ep, ev;
    sel = cfg_dynamic_i ? m_active : int'(cfg_scheme_i);
    ep  = idle_i ? pred_of(sel) : 7;
    ev  = (ep != 7);
    n_vec++;
    if (int'(pred_port_o) != ep || int'(pred_vld_o) != ev) begin
      n_bad++;
      $display("FAIL %s: port %0d vld %0d, expected port %0d vld %0d at %0t",
               cur_req, pred_port_o, pred_vld_o, ep, ev, $time);
    end
  endtask

  task automatic cycle();
    #1;
    check();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic drive(input bit idl, input int dir, input bit rv, input int rp);
    idle_i = idl; arrive_dir_i = 3'(dir); route_vld_i = rv; route_port_i = 3'(rp);
    cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d, expected under 100000", n_cyc);
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: reset state, straight-ahead on X+
    cur_req = "R1";
    #1; check();
    cfg_scheme_i = 2'd1; #1; check();
    cfg_scheme_i = 2'd0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    drive(1, 0, 0, 0);

    // R3: straight-ahead over directions
    cur_req = "R3";
    for (int d = 0; d < 8; d++) drive(1, d, 0, 0);

    // R2: no guess while busy
    cur_req = "R2";
    for (int d = 0; d < 4; d++) drive(0, d, 0, 0);

    // R4: last-port
    cur_req = "R4";
    cfg_scheme_i = 2'd1;
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 2);
    drive(1, 0, 0, 0);
    drive(1, 0, 1, 6);
    drive(1, 0, 1, 5);
    drive(1, 0, 0, 0);
    drive(1, 0, 1, 4);
    drive(1, 0, 0, 0);

    // R5: custom
    cur_req = "R5";
    cfg_scheme_i = 2'd2;
    for (int c = 0; c < 8; c++) begin cfg_custom_port_i = 3'(c); drive(1, 1, 0, 0); end

    // R6: frequency-context incl. ties and saturation
    cur_req = "R6";
    cfg_scheme_i = 2'd3;
    drive(1, 0, 1, 0);
    drive(1, 0, 0, 0);
    drive(1, 0, 1, 1);
    drive(1, 0, 1, 0);
    drive(1, 0, 1, 3);
    drive(1, 0, 1, 0);
    drive(1, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin
      drive(1, 0, 1, (k % 2) ? 0 : 2);
      drive(1, 0, 1, 1);
      drive(1, 0, 1, 0);
    end
    drive(1, 0, 0, 0);

    // R7: static selection changes immediately
    cur_req = "R7";
    cfg_custom_port_i = 3'd3;
    for (int s = 0; s < 4; s++) begin cfg_scheme_i = 2'(s); drive(1, 2, 0, 0); end

    // R10: entering dynamic keeps configured scheme until first window end
    cur_req = "R10";
    cfg_scheme_i = 2'd2; cfg_epoch_i = 16'd6;
    drive(1, 1, 0, 0);
    cfg_dynamic_i = 1'b1;
    cfg_scheme_i = 2'd0;
    for (int k = 0; k < 5; k++) drive(1, 1, 0, 0);

    // R9: last-port should win a window with repeated ports
    cur_req = "R9";
    cfg_custom_port_i = 3'd0;
    for (int k = 0; k < 24; k++) drive(1, 1, 1, (k / 4) % 2 ? 4 : 2);
    cfg_epoch_i = 16'd0;
    for (int k = 0; k < 10; k++) drive(1, k % 4, 1, k % 4);
    cfg_epoch_i = 16'd1;
    for (int k = 0; k < 10; k++) drive(1, 3, k % 2, 3);

    // R8: saturating hits produce ties resolved to lowest code
    cur_req = "R8";
    cfg_epoch_i = 16'd60;
    for (int k = 0; k < 70; k++) drive(k % 3 != 0, 0, 1, 0);
    cfg_custom_port_i = 3'd2;
    for (int k = 0; k < 70; k++) drive(1, 1, 1, 2);

    // R9: mixed traffic with changing window lengths and mode
    cur_req = "R9";
    for (int k = 0; k < 4000; k++) begin
      if (k % 500 == 0)  cfg_dynamic_i = ~cfg_dynamic_i;
      if (k % 97 == 0)   cfg_epoch_i = 16'($urandom % 40);
      if (k % 53 == 0)   cfg_scheme_i = 2'($urandom % 4);
      if (k % 211 == 0)  cfg_custom_port_i = 3'($urandom % 6);
      drive(($urandom % 4) != 0, int'($urandom % 6), ($urandom % 3) == 0, int'($urandom % 7));
    end

    finish_run();
  end
endmodule